// File: doc/BRIEF.md
# Protected-Mode Far Call Classifier

This block decides what a far call does once the target descriptor has been fetched. It takes the target selector, the current privilege level, the limit of the descriptor table, the operating mode bits and the decoded kind, privilege level and present bit of the fetched descriptor. From these it either names the kind of transfer to perform or reports a single fault with its class and error code.

The checks run in a fixed priority order: null selector first, then the table limit, then the type-specific privilege rules, then presence, then the late checks for task gates. Only the first failure is reported. The outcome is registered, so it appears one clock after the inputs are presented. The sequencer that owns the descriptor fetch, the stack pushes and any task switch reads the outcome. For a successful call to a code segment, the block also supplies the new code selector, with its requested privilege field replaced by the current level.

Top module: `far_call_gatekeeper`

## Requirements
- R1: When `prot_en` is 0, or `v86` is 1, the outcome is real-mode far (kind 1), with no fault, error code 0, and `new_cs` equal to `tgt_sel`. No descriptor input has any influence.
- R2: In protected mode, a null selector faults with GP. A null selector has index bits [15:3] equal to 0 and table bit [2] equal to 0, whatever its RPL. The error code is 0. A selector of index 0 in the local table (bit 2 set) is not null.
- R3: A selector whose last byte (`{tgt_sel[15:3],3'b111}`) exceeds `tbl_limit` faults with GP. The error code is the selector with bits [1:0] cleared. A last byte equal to the limit passes.
- R4: Conforming code (descriptor kind 1) faults with GP when the descriptor DPL is greater than CPL. The selector RPL is not considered.
- R5: Non-conforming code (descriptor kind 2) faults with GP when RPL is greater than CPL or when DPL differs from CPL.
- R6: A call gate (kind 3), task gate (kind 4) or available TSS (kind 5) faults with GP when the descriptor DPL is below CPL or below RPL.
- R7: A descriptor that passes its privilege rule but is not present faults with NP, with the selector (bits [1:0] cleared) as the error code. A privilege failure takes priority over absence.
- R8: A busy TSS (kind 6) faults with GP whether or not it is present. Kinds 0 and 7 fault with GP. Both use the selector error code.
- R9: A present task gate whose TSS selector `gate_tss_sel` has bit 2 set faults with GP, with that TSS selector (bits [1:0] cleared) as the error code.
- R10: On success, the kind output is code call 2, call gate 3, task gate 4 or TSS 5. For kind 2, `new_cs` is the target selector with bits [1:0] replaced by CPL. For the other kinds, `new_cs` is 0.
- R11: Fault class encoding is 0 none, 1 GP, 2 NP. The outputs are registered with one cycle of latency. Under reset, all outputs are 0. A nonzero fault class always comes with kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protected mode enabled |
| v86 | input | 1 | Virtual-8086 mode |
| tgt_sel | input | 16 | Target selector: index [15:3], table bit [2], RPL [1:0] |
| cpl | input | 2 | Current privilege level |
| tbl_limit | input | 16 | Byte limit of the selected descriptor table |
| desc_kind | input | 3 | 0 data, 1 conforming code, 2 non-conforming code, 3 call gate, 4 task gate, 5 TSS free, 6 TSS busy, 7 reserved |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| gate_tss_sel | input | 16 | TSS selector held in a task gate |
| call_kind | output | 3 | 0 fault, 1 real far, 2 code, 3 call gate, 4 task gate, 5 TSS |
| fault_cls | output | 2 | 0 none, 1 GP, 2 NP |
| err_code | output | 16 | Fault error code |
| new_cs | output | 16 | New code selector |

## Verification
The hardest situations to reach are those where two checks fail at once. Examples are a gate that is both underprivileged and absent, a busy TSS that is also absent, and a local-table task gate that is not present. Only the ordering of the checks decides which fault is reported in these cases. The stimulus table builds each such double failure on purpose, next to the matching single failures. Boundary vectors put the selector's last byte exactly on the limit and one step past it.

// File: rtl/far_call_gatekeeper.sv
module far_call_gatekeeper #(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic             v86,
  input  logic [SEL_W-1:0] tgt_sel,
  input  logic [1:0]       cpl,
  input  logic [SEL_W-1:0] tbl_limit,
  input  logic [2:0]       desc_kind,
  input  logic [1:0]       desc_dpl,
  input  logic             desc_present,
  input  logic [SEL_W-1:0] gate_tss_sel,
  output logic [2:0]       call_kind,
  output logic [1:0]       fault_cls,
  output logic [SEL_W-1:0] err_code,
  output logic [SEL_W-1:0] new_cs
);
  localparam logic [2:0] K_FAULT = 3'd0, K_REAL = 3'd1, K_CODE = 3'd2,
                         K_GATE = 3'd3, K_TGATE = 3'd4, K_TSS = 3'd5;
  localparam logic [1:0] F_NONE = 2'd0, F_GP = 2'd1, F_NP = 2'd2;

  logic [1:0]       rpl;
  logic [SEL_W-1:0] sel_ec, last_byte;
  logic             is_null, gate_bad;
  assign rpl       = tgt_sel[1:0];
  assign sel_ec    = {tgt_sel[SEL_W-1:2], 2'b00};
  assign last_byte = {tgt_sel[SEL_W-1:3], 3'b111};
  assign is_null   = (tgt_sel[SEL_W-1:3] == '0) && !tgt_sel[2];
  assign gate_bad  = (desc_dpl < cpl) || (desc_dpl < rpl);

  logic [2:0]       k_d;
  logic [1:0]       f_d;
  logic [SEL_W-1:0] e_d, cs_d;

  always_comb begin
    k_d = K_FAULT; f_d = F_NONE; e_d = '0; cs_d = '0;
    if (!prot_en || v86) begin
      k_d = K_REAL; cs_d = tgt_sel;
    end else if (is_null) begin
      f_d = F_GP;
    end else if (last_byte > tbl_limit) begin
      f_d = F_GP; e_d = sel_ec;
    end else begin
      case (desc_kind)
        3'd1, 3'd2: begin
          if ((desc_kind == 3'd1) ? (desc_dpl > cpl) : ((rpl > cpl) || (desc_dpl != cpl))) begin
            f_d = F_GP; e_d = sel_ec;
          end else if (!desc_present) begin
            f_d = F_NP; e_d = sel_ec;
          end else begin
            k_d = K_CODE; cs_d = {tgt_sel[SEL_W-1:2], cpl};
          end
        end
        3'd3, 3'd4, 3'd5: begin
          if (gate_bad) begin
            f_d = F_GP; e_d = sel_ec;
          end else if (!desc_present) begin
            f_d = F_NP; e_d = sel_ec;
          end else if (desc_kind == 3'd4 && gate_tss_sel[2]) begin
            f_d = F_GP; e_d = {gate_tss_sel[SEL_W-1:2], 2'b00};
          end else begin
            k_d = (desc_kind == 3'd3) ? K_GATE : (desc_kind == 3'd4) ? K_TGATE : K_TSS;
          end
        end
        default: begin
          f_d = F_GP; e_d = sel_ec;
        end
      endcase
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_kind <= K_FAULT; fault_cls <= F_NONE; err_code <= '0; new_cs <= '0; primed <= 1'b0;
    end else begin
      call_kind <= k_d; fault_cls <= f_d; err_code <= e_d; new_cs <= cs_d; primed <= 1'b1;
    end
  end

  p_real_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!prot_en || v86) |-> call_kind == K_REAL && fault_cls == F_NONE && new_cs == $past(tgt_sel));
  p_null_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(prot_en && !v86 && tgt_sel[SEL_W-1:2] == '0) |-> fault_cls == F_GP && err_code == '0);
  p_code_rpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    primed && call_kind == K_CODE |-> new_cs[1:0] == $past(cpl) && new_cs[SEL_W-1:2] == $past(tgt_sel[SEL_W-1:2]));
  p_fault_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cls != F_NONE |-> call_kind == K_FAULT && new_cs == '0);
  p_np_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && fault_cls == F_NP |-> !$past(desc_present) && err_code[1:0] == 2'b00);
  p_busy_gp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(prot_en && !v86 && desc_kind == 3'd6) |-> fault_cls == F_GP);
endmodule

// File: tb/far_call_gatekeeper_bench.sv
`timescale 1ns/1ps
module far_call_gatekeeper_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic prot_en, v86, desc_present;
  logic [15:0] tgt_sel, tbl_limit, gate_tss_sel, err_code, new_cs;
  logic [1:0] cpl, desc_dpl, fault_cls;
  logic [2:0] desc_kind, call_kind;

  far_call_gatekeeper u_far_call_gatekeeper (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .v86(v86), .tgt_sel(tgt_sel), .cpl(cpl),
    .tbl_limit(tbl_limit), .desc_kind(desc_kind), .desc_dpl(desc_dpl), .desc_present(desc_present),
    .gate_tss_sel(gate_tss_sel), .call_kind(call_kind), .fault_cls(fault_cls),
    .err_code(err_code), .new_cs(new_cs));

  typedef struct packed {
    logic pe; logic vm; logic [15:0] sel; logic [1:0] cp; logic [15:0] lim;
    logic [2:0] kd; logic [1:0] dp; logic pr; logic [15:0] ts;
    logic [2:0] ek; logic [1:0] ef; logic [15:0] ee; logic [15:0] ecs; logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TV [NV] = '{
    '{1'b0,1'b0,16'h1234,2'd0,16'h00FF,3'd6,2'd0,1'b0,16'h0000, 3'd1,2'd0,16'h0000,16'h1234,4'd1},  // R1 real
    '{1'b1,1'b1,16'h0000,2'd3,16'h0000,3'd0,2'd0,1'b0,16'h0000, 3'd1,2'd0,16'h0000,16'h0000,4'd1},  // R1 v86
    '{1'b1,1'b0,16'h0003,2'd3,16'h00FF,3'd2,2'd3,1'b1,16'h0000, 3'd0,2'd1,16'h0000,16'h0000,4'd2},  // R2 null
    '{1'b1,1'b0,16'h0004,2'd0,16'h00FF,3'd2,2'd0,1'b1,16'h0000, 3'd2,2'd0,16'h0000,16'h0004,4'd2},  // R2 local idx0
    '{1'b1,1'b0,16'h0100,2'd0,16'h00FF,3'd2,2'd0,1'b1,16'h0000, 3'd0,2'd1,16'h0100,16'h0000,4'd3},  // R3 past limit
    '{1'b1,1'b0,16'h00FB,2'd3,16'h00FF,3'd2,2'd3,1'b1,16'h0000, 3'd2,2'd0,16'h0000,16'h00FB,4'd3},  // R3 on limit
    '{1'b1,1'b0,16'h0013,2'd2,16'h00FF,3'd1,2'd0,1'b1,16'h0000, 3'd2,2'd0,16'h0000,16'h0012,4'd4},  // R4 ok
    '{1'b1,1'b0,16'h0011,2'd2,16'h00FF,3'd1,2'd3,1'b1,16'h0000, 3'd0,2'd1,16'h0010,16'h0000,4'd4},  // R4 dpl>cpl
    '{1'b1,1'b0,16'h0023,2'd2,16'h00FF,3'd2,2'd2,1'b1,16'h0000, 3'd0,2'd1,16'h0020,16'h0000,4'd5},  // R5 rpl>cpl
    '{1'b1,1'b0,16'h0020,2'd2,16'h00FF,3'd2,2'd1,1'b1,16'h0000, 3'd0,2'd1,16'h0020,16'h0000,4'd5},  // R5 dpl!=cpl
    '{1'b1,1'b0,16'h0021,2'd2,16'h00FF,3'd2,2'd2,1'b1,16'h0000, 3'd2,2'd0,16'h0000,16'h0022,4'd10}, // R10 code cs
    '{1'b1,1'b0,16'h0021,2'd2,16'h00FF,3'd2,2'd2,1'b0,16'h0000, 3'd0,2'd2,16'h0020,16'h0000,4'd7},  // R7 np
    '{1'b1,1'b0,16'h0030,2'd3,16'h00FF,3'd3,2'd3,1'b1,16'h0000, 3'd3,2'd0,16'h0000,16'h0000,4'd10}, // R10 gate
    '{1'b1,1'b0,16'h0030,2'd3,16'h00FF,3'd3,2'd2,1'b1,16'h0000, 3'd0,2'd1,16'h0030,16'h0000,4'd6},  // R6 dpl<cpl
    '{1'b1,1'b0,16'h0032,2'd0,16'h00FF,3'd3,2'd1,1'b1,16'h0000, 3'd0,2'd1,16'h0030,16'h0000,4'd6},  // R6 dpl<rpl
    '{1'b1,1'b0,16'h0034,2'd0,16'h00FF,3'd3,2'd3,1'b0,16'h0000, 3'd0,2'd2,16'h0034,16'h0000,4'd7},  // R7 gate np
    '{1'b1,1'b0,16'h0030,2'd3,16'h00FF,3'd3,2'd2,1'b0,16'h0000, 3'd0,2'd1,16'h0030,16'h0000,4'd7},  // R7 priv first
    '{1'b1,1'b0,16'h0040,2'd3,16'h00FF,3'd4,2'd3,1'b1,16'h0048, 3'd4,2'd0,16'h0000,16'h0000,4'd10}, // R10 task gate
    '{1'b1,1'b0,16'h0040,2'd3,16'h00FF,3'd4,2'd3,1'b1,16'h004F, 3'd0,2'd1,16'h004C,16'h0000,4'd9},  // R9 local tss
    '{1'b1,1'b0,16'h0040,2'd3,16'h00FF,3'd4,2'd3,1'b0,16'h004F, 3'd0,2'd2,16'h0040,16'h0000,4'd9},  // R9 np first
    '{1'b1,1'b0,16'h0050,2'd1,16'h00FF,3'd5,2'd3,1'b1,16'h0000, 3'd5,2'd0,16'h0000,16'h0000,4'd10}, // R10 tss
    '{1'b1,1'b0,16'h0050,2'd1,16'h00FF,3'd6,2'd3,1'b1,16'h0000, 3'd0,2'd1,16'h0050,16'h0000,4'd8},  // R8 busy
    '{1'b1,1'b0,16'h0050,2'd1,16'h00FF,3'd6,2'd3,1'b0,16'h0000, 3'd0,2'd1,16'h0050,16'h0000,4'd8},  // R8 busy absent
    '{1'b1,1'b0,16'h0058,2'd0,16'h00FF,3'd0,2'd0,1'b1,16'h0000, 3'd0,2'd1,16'h0058,16'h0000,4'd8},  // R8 data
    '{1'b1,1'b0,16'h005A,2'd0,16'h00FF,3'd7,2'd3,1'b1,16'h0000, 3'd0,2'd1,16'h0058,16'h0000,4'd8}   // R8 reserved
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic apply(input vec_t v);
    prot_en = v.pe; v86 = v.vm; tgt_sel = v.sel; cpl = v.cp; tbl_limit = v.lim;
    desc_kind = v.kd; desc_dpl = v.dp; desc_present = v.pr; gate_tss_sel = v.ts;
  endtask

  task automatic check(input int req, input logic [2:0] ek, input logic [1:0] ef,
                       input logic [15:0] ee, input logic [15:0] ecs);
    checks++;
    if (call_kind !== ek || fault_cls !== ef || err_code !== ee || new_cs !== ecs) begin
      errors++;
      $display("FAIL R%0d: got kind=%0d fault=%0d err=%h cs=%h, expected kind=%0d fault=%0d err=%h cs=%h",
               req, call_kind, fault_cls, err_code, new_cs, ek, ef, ee, ecs);
    end
  endtask

  initial begin
    apply(TV[0]);
    repeat (3) @(negedge clk);
    check(11, 3'd0, 2'd0, 16'h0000, 16'h0000);       // R11 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); apply(TV[i]);
      @(negedge clk); check(int'(TV[i].req), TV[i].ek, TV[i].ef, TV[i].ee, TV[i].ecs);
    end
    // R1: descriptor inputs changed in real mode have no effect
    @(negedge clk); apply(TV[0]); desc_kind = 3'd3; desc_dpl = 2'd3; desc_present = 1'b1; tbl_limit = 16'h0000;
    @(negedge clk); check(1, 3'd1, 2'd0, 16'h0000, 16'h1234);
    // R11: one cycle latency, output follows registered input
    @(negedge clk); apply(TV[4]);
    #1 check(11, 3'd1, 2'd0, 16'h0000, 16'h1234);
    @(negedge clk); check(11, 3'd0, 2'd1, 16'h0100, 16'h0000);
    // R11: reset clears a fault outcome
    rst_n = 1'b0;
    @(negedge clk); check(11, 3'd0, 2'd0, 16'h0000, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule